// File: doc/BRIEF.md
# RGB to RGBS Colour Quantizer

This block takes a stream of pixels, each carried as three 8-bit channel values, and turns every pixel into a one-byte palette code. The byte holds a 2-bit level for each of red, green and blue, plus a 2-bit shading level that moves the displayed colour toward white. Each colour level is the top two bits of its channel, so the four codes each cover an equal quarter of the input range.

The shading level is not taken from any single channel. A brightness score is formed by adding the three pairwise channel sums. That score is then compared with three thresholds that can be written at runtime. The shading level is the number of thresholds the score reaches, so ascending thresholds give levels 0 to 3. A second output gives a 4-bit reduced code made of the most significant bit of each of the four fields.

Pixels enter with a valid strobe. Results come out of registers two cycles later, with a matching valid. Between valid pixels, both codes keep their last value.

Top module: `rgbs_quantizer`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_code` and `out_nibble` become 0 and the three thresholds return to 384, 768 and 1152 (index 0, 1, 2).
- R2: For an accepted pixel, `out_code[7:6]` = `in_r[7:6]`, `out_code[5:4]` = `in_g[7:6]` and `out_code[3:2]` = `in_b[7:6]`.
- R3: The score is (R+G)+(G+B)+(R+B), an 11-bit value. `out_code[1:0]` is the number of thresholds for which score >= threshold, so a score equal to a threshold counts as reaching it.
- R4: When `thr_we` is high at a clock edge, `thr_data` is written into the threshold selected by `thr_idx` (0, 1 or 2). A write with `thr_idx` = 3 changes no threshold.
- R5: A pixel accepted at the same edge as a threshold write is graded with the old threshold value. Pixels accepted at later edges use the new value.
- R6: A pixel accepted with `in_valid` high at edge k appears on the outputs after edge k+2, where `out_valid` is high. `out_valid` is low in every other cycle.
- R7: `out_nibble` = {`out_code[7]`, `out_code[5]`, `out_code[3]`, `out_code[1]`}.
- R8: When no pixel is delivered, `out_code` and `out_nibble` keep their previous values and ignore the data inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present on the channel inputs |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| thr_we | input | 1 | Threshold write strobe |
| thr_idx | input | 2 | Threshold select (0..2; 3 is ignored) |
| thr_data | input | 11 | Threshold value to write |
| out_valid | output | 1 | Output codes are new this cycle |
| out_code | output | 8 | RGBS byte {R, G, B, S} |
| out_nibble | output | 4 | MSB of each RGBS field |

## Verification
A threshold write and a pixel can arrive at the same clock edge. The bench makes this happen by presenting a pixel whose score equals the old lowest threshold together with a write that raises that threshold by one. It then sends the same pixel again in the next cycle. The first result must still show shading level 1, and the second must drop to level 0. Reads of all output codes are timed to the two-cycle latency so that the two results are told apart.

// File: rtl/rgbs_pkg.sv
package rgbs_pkg;

    localparam int CH_W    = 8;
    localparam int FIELD_W = 2;
    localparam int N_THR   = 3;
    localparam int SCORE_W = CH_W + 3;
    localparam int LVL_W   = $clog2(N_THR + 1);
    localparam int CODE_W  = 4 * FIELD_W;
    localparam int IDX_W   = $clog2(N_THR + 1);

    typedef logic [CH_W-1:0]    chan_t;
    typedef logic [SCORE_W-1:0] score_t;
    typedef logic [LVL_W-1:0]   level_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef struct packed {
        logic [FIELD_W-1:0] r;
        logic [FIELD_W-1:0] g;
        logic [FIELD_W-1:0] b;
    } hue_t;

    function automatic score_t pair_score(chan_t r, chan_t g, chan_t b);
        score_t zr, zg, zb;
        zr = score_t'(r);
        zg = score_t'(g);
        zb = score_t'(b);
        return (zr + zg) + (zg + zb) + (zr + zb);
    endfunction

    function automatic hue_t top_bits(chan_t r, chan_t g, chan_t b);
        hue_t h;
        h.r = r[CH_W-1 -: FIELD_W];
        h.g = g[CH_W-1 -: FIELD_W];
        h.b = b[CH_W-1 -: FIELD_W];
        return h;
    endfunction

    function automatic code_t pack_code(hue_t h, level_t s);
        return {h.r, h.g, h.b, s[FIELD_W-1:0]};
    endfunction

    function automatic logic [3:0] reduce_code(code_t c);
        return {c[CODE_W-1], c[CODE_W-1-FIELD_W], c[CODE_W-1-2*FIELD_W], c[FIELD_W-1]};
    endfunction

endpackage

// File: rtl/rgbs_thresh_bank.sv
module rgbs_thresh_bank
    import rgbs_pkg::*;
#(
    parameter logic [N_THR*SCORE_W-1:0] THR_INIT = {11'd1152, 11'd768, 11'd384}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  score_t           wr_val,
    output score_t           thr_q [N_THR]
);

    for (genvar i = 0; i < N_THR; i++) begin : g_thr
        always_ff @(posedge clk) begin
            if (rst) begin
                thr_q[i] <= THR_INIT[i*SCORE_W +: SCORE_W];
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                thr_q[i] <= wr_val;
            end
        end
    end

endmodule

// File: rtl/rgbs_grade_stage.sv
module rgbs_grade_stage
    import rgbs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   px_valid,
    input  chan_t  px_r,
    input  chan_t  px_g,
    input  chan_t  px_b,
    input  score_t thr [N_THR],
    output logic   st_valid,
    output hue_t   st_hue,
    output level_t st_level
);

    score_t             score;
    logic [N_THR-1:0]   reached;
    level_t             level;

    assign score = pair_score(px_r, px_g, px_b);

    for (genvar i = 0; i < N_THR; i++) begin : g_cmp
        assign reached[i] = (score >= thr[i]);
    end

    always_comb begin
        level = '0;
        for (int i = 0; i < N_THR; i++) begin
            level = level + level_t'(reached[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= 1'b0;
            st_hue   <= '0;
            st_level <= '0;
        end else begin
            st_valid <= px_valid;
            if (px_valid) begin
                st_hue   <= top_bits(px_r, px_g, px_b);
                st_level <= level;
            end
        end
    end

endmodule

// File: rtl/rgbs_pack_stage.sv
module rgbs_pack_stage
    import rgbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       st_valid,
    input  hue_t       st_hue,
    input  level_t     st_level,
    output logic       q_valid,
    output code_t      q_code,
    output logic [3:0] q_nibble
);

    code_t code_d;
    assign code_d = pack_code(st_hue, st_level);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid  <= 1'b0;
            q_code   <= '0;
            q_nibble <= '0;
        end else begin
            q_valid <= st_valid;
            if (st_valid) begin
                q_code   <= code_d;
                q_nibble <= reduce_code(code_d);
            end
        end
    end

endmodule

// File: rtl/rgbs_quantizer.sv
module rgbs_quantizer
    import rgbs_pkg::*;
#(
    parameter logic [N_THR*SCORE_W-1:0] THR_INIT = {11'd1152, 11'd768, 11'd384}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [CH_W-1:0]    in_r,
    input  logic [CH_W-1:0]    in_g,
    input  logic [CH_W-1:0]    in_b,
    input  logic               thr_we,
    input  logic [IDX_W-1:0]   thr_idx,
    input  logic [SCORE_W-1:0] thr_data,
    output logic               out_valid,
    output logic [CODE_W-1:0]  out_code,
    output logic [3:0]         out_nibble
);

    score_t thr [N_THR];
    logic   st_valid;
    hue_t   st_hue;
    level_t st_level;

    rgbs_thresh_bank #(.THR_INIT(THR_INIT)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (thr_we),
        .wr_idx (thr_idx),
        .wr_val (thr_data),
        .thr_q  (thr)
    );

    rgbs_grade_stage u_grade (
        .clk      (clk),
        .rst      (rst),
        .px_valid (in_valid),
        .px_r     (in_r),
        .px_g     (in_g),
        .px_b     (in_b),
        .thr      (thr),
        .st_valid (st_valid),
        .st_hue   (st_hue),
        .st_level (st_level)
    );

    rgbs_pack_stage u_pack (
        .clk      (clk),
        .rst      (rst),
        .st_valid (st_valid),
        .st_hue   (st_hue),
        .st_level (st_level),
        .q_valid  (out_valid),
        .q_code   (out_code),
        .q_nibble (out_nibble)
    );

endmodule

// File: rtl/rgbs_quantizer_chk.sv
module rgbs_quantizer_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_r,
    input logic       out_valid,
    input logic [7:0] out_code,
    input logic [3:0] out_nibble
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1: reset clears the output valid
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_code == 8'h00));

    // R6: valid follows the input valid two edges later
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2: red field tracks the top bits of the red input
    a_r2_red_field: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid) |-> (out_code[7:6] == $past(in_r[7:6], 2)));

    // R7: reduced code agrees with the full code
    a_r7_nibble_match: assert property (@(posedge clk) disable iff (rst)
        out_nibble == {out_code[7], out_code[5], out_code[3], out_code[1]});

    // R8: no delivered pixel, no change
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && !$past(in_valid, 2)) |-> ($stable(out_code) && $stable(out_nibble)));

endmodule

bind rgbs_quantizer rgbs_quantizer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_r       (in_r),
    .out_valid  (out_valid),
    .out_code   (out_code),
    .out_nibble (out_nibble)
);

// File: tb/sim_rgbs_quantizer.sv
`timescale 1ns/1ps
module sim_rgbs_quantizer;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_r, in_g, in_b;
    logic        thr_we;
    logic [1:0]  thr_idx;
    logic [10:0] thr_data;
    logic        out_valid;
    logic [7:0]  out_code;
    logic [3:0]  out_nibble;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rgbs_quantizer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .thr_we(thr_we), .thr_idx(thr_idx), .thr_data(thr_data),
        .out_valid(out_valid), .out_code(out_code), .out_nibble(out_nibble)
    );

    // {r, g, b, expected code} with default thresholds 384/768/1152
    localparam int NV = 8;
    localparam logic [31:0] VEC [NV] = '{
        {8'd0,   8'd0,   8'd0,   8'h00},
        {8'd255, 8'd255, 8'd255, 8'hFF},
        {8'd255, 8'd0,   8'd0,   8'hC1},
        {8'd64,  8'd128, 8'd192, 8'h6E},
        {8'd63,  8'd127, 8'd191, 8'h19},
        {8'd96,  8'd96,  8'd0,   8'h51},
        {8'd200, 8'd200, 8'd176, 8'hFB},
        {8'd200, 8'd200, 8'd175, 8'hFA}
    };

    function automatic logic [3:0] nib_of(logic [7:0] c);
        return {c[7], c[5], c[3], c[1]};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, logic [7:0] exp);
        chk(req, int'(out_valid), 1);
        chk(req, int'(out_code), int'(exp));
        chk("R7", int'(out_nibble), int'(nib_of(exp)));
    endtask

    task automatic drive_px(logic [7:0] r, logic [7:0] g, logic [7:0] b);
        in_valid = 1'b1; in_r = r; in_g = g; in_b = b;
    endtask

    task automatic idle();
        in_valid = 1'b0; thr_we = 1'b0;
    endtask

    // one pixel, checked after its two-edge latency
    task automatic single(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                          logic [7:0] exp, string req);
        @(negedge clk); drive_px(r, g, b);
        @(negedge clk); idle();
        chk("R6", int'(out_valid), 0);
        @(negedge clk);
        chk_out(req, exp);
    endtask

    task automatic write_thr(logic [1:0] idx, logic [10:0] val);
        @(negedge clk);
        thr_we = 1'b1; thr_idx = idx; thr_data = val;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_r = 8'hAA; in_g = 8'h55; in_b = 8'h33;
        thr_we = 1'b0; thr_idx = 2'd0; thr_data = 11'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", int'(out_valid), 0);
        chk("R1", int'(out_code), 0);
        chk("R1", int'(out_nibble), 0);
        rst = 1'b0;

        // R2 R3 R7: vector table, one pixel at a time
        for (int i = 0; i < NV; i++) begin
            single(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0], "R2R3");
        end

        // R6: back-to-back stream, one result per cycle
        @(negedge clk); drive_px(VEC[1][31:24], VEC[1][23:16], VEC[1][15:8]);
        @(negedge clk); drive_px(VEC[3][31:24], VEC[3][23:16], VEC[3][15:8]);
        @(negedge clk); drive_px(VEC[4][31:24], VEC[4][23:16], VEC[4][15:8]);
        chk_out("R6", VEC[1][7:0]);
        @(negedge clk); idle();
        chk_out("R6", VEC[3][7:0]);
        @(negedge clk);
        chk_out("R6", VEC[4][7:0]);
        @(negedge clk);
        chk("R6", int'(out_valid), 0);

        // R8: idle with changing data keeps the codes
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_r = 8'(k * 70); in_g = 8'hFF; in_b = 8'(k * 33);
            chk("R8", int'(out_code), int'(VEC[4][7:0]));
            chk("R8", int'(out_nibble), int'(nib_of(VEC[4][7:0])));
        end

        // R3 R4: lower threshold 0 to zero, black now reaches level 1
        write_thr(2'd0, 11'd0);
        single(8'd0, 8'd0, 8'd0, 8'h01, "R4");
        // R3: equality at raised top threshold
        write_thr(2'd2, 11'd1530);
        single(8'd255, 8'd255, 8'd255, 8'hFF, "R3");
        single(8'd255, 8'd255, 8'd254, 8'hFE, "R3");

        // R1: reset restores default thresholds
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", int'(out_valid), 0);
        single(8'd0, 8'd0, 8'd0, 8'h00, "R1");
        single(8'd200, 8'd200, 8'd176, 8'hFB, "R1");

        // R4: index 3 write changes nothing
        write_thr(2'd3, 11'd0);
        single(8'd0, 8'd0, 8'd0, 8'h00, "R4");
        single(8'd96, 8'd96, 8'd0, 8'h51, "R4");

        // R5: write and pixel at the same edge
        @(negedge clk);
        drive_px(8'd96, 8'd96, 8'd0);
        thr_we = 1'b1; thr_idx = 2'd0; thr_data = 11'd385;
        @(negedge clk);
        thr_we = 1'b0;
        drive_px(8'd96, 8'd96, 8'd0);
        @(negedge clk); idle();
        chk_out("R5", 8'h51);
        @(negedge clk);
        chk_out("R5", 8'h50);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule